// File: doc/BRIEF.md
# Hamming-Protected Pipeline Stage

This block is a two-register synchronous stage built around a small 8-bit combinational function. The data word passes through the stage in two steps. First it is encoded into a 12-bit single-error-correcting Hamming codeword and captured in an input register. That stored word is corrected and fed to the function. The function's result is then encoded and captured in an output register, and the output register's word is corrected again to drive the 8-bit result port.

The point of the stage is upset tolerance. If any one bit of either stored word flips, that flip is repaired before the value reaches the function or the output. A flag reports every cycle in which a register holds a damaged word. Each register has a fault-injection mask input, so an upset can be planted deliberately at the moment of capture. A glitch inside the combinational function that is then captured is not repaired, because it is encoded as if it were valid data. A build parameter selects the function: an increment by one, or an XOR with a fixed key.

Top module: `ecc_pipe_stage`

## Requirements
- R1: While `rst_n` is low, `dout` reads 0 and both error flags read 0.
- R2: With FUNC_SEL = 0 and at most one set bit in each mask, `dout` equals (`din` + 1) mod 256. The `din` value used is the one sampled two rising clock edges earlier.
- R3: With FUNC_SEL = 1, under the same conditions as R2, `dout` equals `din` XOR XOR_KEY. The default key is 8'h5A.
- R4: The stored codeword uses positions 1 to 12, and position p sits at vector bit p-1. Check bits are at positions 1, 2, 4 and 8, chosen for even parity. Data bits 0 to 7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Setting bit p-1 of a mask inverts position p of the word captured at that edge.
- R5: A single set bit in `flip_in_mask`, at any of the 12 positions, leaves `dout` unchanged from the R2/R3 value.
- R6: A single set bit in `flip_out_mask`, at any of the 12 positions, leaves `dout` unchanged in the cycle that the damaged word is held.
- R7: Single flips planted in both registers in the same cycle are each corrected, and `dout` stays correct.
- R8: `err_in` is high exactly in the cycles after an edge that captured the input register with exactly one mask bit set. `err_out` does the same for the output register. With all-zero masks, both flags stay low.
- R9: Reset is asynchronous. Driving `rst_n` low between clock edges clears `dout` and both flags at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 8 | Data entering the stage |
| flip_in_mask | input | 12 | Bits XORed into the input codeword at capture |
| flip_out_mask | input | 12 | Bits XORed into the output codeword at capture |
| dout | output | 8 | Corrected result of the output register |
| err_in | output | 1 | Input register syndrome is nonzero |
| err_out | output | 1 | Output register syndrome is nonzero |

## Verification
All 256 input values are streamed through the stage four times. The first pass uses clean masks, which separates a wrong function or a wrong latency from a correction fault. The second pass rotates a single flip through every position of the input register. The third pass does the same for the output register. The fourth pass plants flips in both registers at once, at different positions, so that a corrector that repairs only check bits, or only data bits, or that uses a wrong position map, is exposed through `dout` and the flags. An XOR-mode instance runs alongside on the same stimulus. An asynchronous reset is also asserted mid-stream and checked before the next edge.

// File: rtl/ecc_stage_pkg.sv
package ecc_stage_pkg;

    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int CODE_W = DATA_W + PAR_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [PAR_W-1:0]  synd_t;

    typedef struct packed {
        code_t in_word;
        code_t out_word;
    } stage_regs_t;

    // Positions are counted from 1; a power of two holds a check bit.
    function automatic bit is_check_pos(int pos);
        return (pos & (pos - 1)) == 0;
    endfunction

    function automatic code_t scatter_data(data_t d);
        code_t w;
        int    k;
        w = '0;
        k = 0;
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (!is_check_pos(pos)) begin
                w[pos-1] = d[k];
                k++;
            end
        end
        return w;
    endfunction

    function automatic data_t gather_data(code_t w);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (!is_check_pos(pos)) begin
                d[k] = w[pos-1];
                k++;
            end
        end
        return d;
    endfunction

    // Bit j of the syndrome covers every position whose index has bit j set.
    function automatic synd_t calc_syndrome(code_t w);
        synd_t s;
        s = '0;
        for (int j = 0; j < PAR_W; j++) begin
            for (int pos = 1; pos <= CODE_W; pos++) begin
                if (((pos >> j) & 1) == 1) begin
                    s[j] = s[j] ^ w[pos-1];
                end
            end
        end
        return s;
    endfunction

    function automatic code_t ecc_encode(data_t d);
        code_t w;
        synd_t s;
        w = scatter_data(d);
        s = calc_syndrome(w);
        for (int j = 0; j < PAR_W; j++) begin
            w[(1 << j) - 1] = s[j];
        end
        return w;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_stage_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);

    always_comb begin
        code_o = ecc_encode(data_i);
    end

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
    import ecc_stage_pkg::*;
(
    input  code_t code_i,
    output data_t data_o,
    output logic  err_o
);

    synd_t synd;
    code_t fixed;

    always_comb begin
        synd  = calc_syndrome(code_i);
        fixed = code_i;
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (int'(synd) == pos) begin
                fixed[pos-1] = ~code_i[pos-1];
            end
        end
        data_o = gather_data(fixed);
        err_o  = (synd != '0);
    end

endmodule

// File: rtl/stage_logic.sv
module stage_logic
    import ecc_stage_pkg::*;
#(
    parameter int                 FUNC_SEL = 0,
    parameter logic [DATA_W-1:0]  XOR_KEY  = 8'h5A
) (
    input  data_t a_i,
    output data_t y_o
);

    generate
        if (FUNC_SEL == 0) begin : g_incr
            assign y_o = a_i + data_t'(1);
        end else begin : g_xor
            assign y_o = a_i ^ XOR_KEY;
        end
    endgenerate

endmodule

// File: rtl/ecc_pipe_stage.sv
module ecc_pipe_stage
    import ecc_stage_pkg::*;
#(
    parameter int                 FUNC_SEL = 0,
    parameter logic [DATA_W-1:0]  XOR_KEY  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] flip_in_mask,
    input  logic [CODE_W-1:0] flip_out_mask,
    output logic [DATA_W-1:0] dout,
    output logic              err_in,
    output logic              err_out
);

    localparam code_t ZERO_CODE = ecc_encode('0);

    stage_regs_t regs_d;
    stage_regs_t regs_q;

    code_t enc_in;
    code_t enc_out;
    data_t core_a;
    data_t core_y;

    ecc_encoder u_enc_in (
        .data_i (din),
        .code_o (enc_in)
    );

    ecc_corrector u_cor_in (
        .code_i (regs_q.in_word),
        .data_o (core_a),
        .err_o  (err_in)
    );

    stage_logic #(
        .FUNC_SEL (FUNC_SEL),
        .XOR_KEY  (XOR_KEY)
    ) u_core (
        .a_i (core_a),
        .y_o (core_y)
    );

    ecc_encoder u_enc_out (
        .data_i (core_y),
        .code_o (enc_out)
    );

    ecc_corrector u_cor_out (
        .code_i (regs_q.out_word),
        .data_o (dout),
        .err_o  (err_out)
    );

    // Masks model an upset landing in the word as it is captured.
    always_comb begin
        regs_d          = regs_q;
        regs_d.in_word  = enc_in ^ flip_in_mask;
        regs_d.out_word = enc_out ^ flip_out_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.in_word  <= ZERO_CODE;
            regs_q.out_word <= ZERO_CODE;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/ecc_pipe_stage_chk.sv
module ecc_pipe_stage_chk
    import ecc_stage_pkg::*;
#(
    parameter int                 FUNC_SEL = 0,
    parameter logic [DATA_W-1:0]  XOR_KEY  = 8'h5A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic [CODE_W-1:0] flip_in_mask,
    input logic [CODE_W-1:0] flip_out_mask,
    input logic [DATA_W-1:0] dout,
    input logic              err_in,
    input logic              err_out
);

    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 2'd0;
        end else if (seen != 2'd2) begin
            seen <= seen + 2'd1;
        end
    end

    function automatic data_t spec_f(data_t d);
        return (FUNC_SEL == 0) ? data_t'(d + data_t'(1)) : (d ^ XOR_KEY);
    endfunction

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (dout == '0 && !err_in && !err_out));

    // R2, R3, R5, R6, R7
    a_r2_function_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd2 && $countones($past(flip_in_mask, 2)) <= 1
                      && $countones($past(flip_out_mask)) <= 1)
        |-> dout == spec_f($past(din, 2)));

    a_r8_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && $countones($past(flip_in_mask)) <= 1)
        |-> err_in == ($countones($past(flip_in_mask)) == 1));

    a_r8_out_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && $countones($past(flip_out_mask)) <= 1)
        |-> err_out == ($countones($past(flip_out_mask)) == 1));

endmodule

bind ecc_pipe_stage ecc_pipe_stage_chk #(
    .FUNC_SEL (FUNC_SEL),
    .XOR_KEY  (XOR_KEY)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .din           (din),
    .flip_in_mask  (flip_in_mask),
    .flip_out_mask (flip_out_mask),
    .dout          (dout),
    .err_in        (err_in),
    .err_out       (err_out)
);

// File: tb/sim_ecc_pipe_stage.sv
`timescale 1ns/100ps
module sim_ecc_pipe_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [7:0]  din = '0;
    logic [11:0] fmi = '0;
    logic [11:0] fmo = '0;
    logic [7:0]  dout0, dout1;
    logic        ei0, eo0, ei1, eo1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0]  hd [0:1];
    logic [11:0] hmi;
    logic [11:0] hmo;
    int          nv = 0;

    always #2 clk = ~clk;

    ecc_pipe_stage #(.FUNC_SEL(0)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .flip_in_mask(fmi),
        .flip_out_mask(fmo), .dout(dout0), .err_in(ei0), .err_out(eo0));

    ecc_pipe_stage #(.FUNC_SEL(1), .XOR_KEY(8'h5A)) u1 (
        .clk(clk), .rst_n(rst_n), .din(din), .flip_in_mask(fmi),
        .flip_out_mask(fmo), .dout(dout1), .err_in(ei1), .err_out(eo1));

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic single(logic [11:0] m);
        return $countones(m) == 1;
    endfunction

    // Sample what the last edge produced, then drive the next inputs.
    task automatic step(string tag, logic [7:0] d, logic [11:0] mi, logic [11:0] mo);
        @(negedge clk);
        if (nv >= 2) begin
            check({tag, " R2 incr"}, dout0, hd[1] + 8'd1);
            check({tag, " R3 xor"}, dout1, hd[1] ^ 8'h5A);
        end
        if (nv >= 1) begin
            check({tag, " R8 err_in"}, {7'd0, ei0}, {7'd0, single(hmi)});
            check({tag, " R8 err_out"}, {7'd0, eo0}, {7'd0, single(hmo)});
        end
        hd[1] = hd[0];
        hd[0] = d;
        hmi   = mi;
        hmo   = mo;
        nv++;
        din = d;
        fmi = mi;
        fmo = mo;
    endtask

    task automatic check_cleared(string tag);
        check({tag, " dout"}, dout0, 8'h00);
        check({tag, " dout xor"}, dout1, 8'h00);
        check({tag, " flags"}, {4'd0, ei0, eo0, ei1, eo1}, 8'h00);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #0.5 check_cleared("R1 reset");
        repeat (3) @(negedge clk);
        check_cleared("R1 held reset");
        rst_n = 1'b1;
        nv = 0;
        // R4/R8: clean masks, every data value
        for (int v = 0; v < 256; v++) step("clean", 8'(v), '0, '0);
        // R5: one flip in the input register, walking all 12 positions
        for (int v = 0; v < 256; v++) step("R5 in-flip", 8'(v), 12'(1 << (v % 12)), '0);
        // R6: one flip in the output register
        for (int v = 0; v < 256; v++) step("R6 out-flip", 8'(255 - v), '0, 12'(1 << (v % 12)));
        // R7: flips in both registers, different positions
        for (int v = 0; v < 256; v++)
            step("R7 both", 8'(v * 37), 12'(1 << (v % 12)), 12'(1 << ((v + 5) % 12)));
        // R9: asynchronous clear between edges
        @(negedge clk);
        din = 8'h77;
        fmi = '0;
        fmo = '0;
        #0.5 rst_n = 1'b0;
        #0.5 check_cleared("R9 async");
        @(negedge clk);
        rst_n = 1'b1;
        nv = 0;
        for (int v = 0; v < 8; v++) step("post-reset", 8'(v + 250), '0, '0);
        step("tail", 8'h00, '0, '0);
        step("tail", 8'h00, '0, '0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule